// File: doc/BRIEF.md
# Per-Frame Short-Command Replayer

This block keeps a small bank of ready-made 32-bit short-packet words and plays them into a downstream display-link packet transmitter at the start of each video frame. Software fills the bank through a simple register write port (address, data, write strobe). The words arrive fully formatted: data type in the low byte, two payload bytes above it, and the header check byte on top. This block does not build or check any of those fields. Software also writes a control word that holds a byte count and an enable bit.

While the enable bit is set, each frame-start strobe snapshots the bank and the byte count. The block then streams the stored bytes, lowest byte of slot 0 first, over a byte-wide valid/ready interface. It stops once the counted number of bytes has been accepted. The list goes out again on every frame until software clears the enable bit. Because of the snapshot, register writes made during a transfer cannot tear the sequence already in flight.

Top module: `frame_cmd_injector`

## Requirements
- R1: After reset every slot holds zero, the enable bit is clear and `out_valid` is low, so a frame-start strobe emits nothing.
- R2: Slot k (k = 0..7) is written at address 0x1b+k. The control word is at 0x1a, with the byte count in bits 15:0 and the enable in bit 31.
- R3: A frame-start strobe with enable set raises `out_valid` on the next cycle. Bytes then leave in ascending slot order, and within each slot from bits 7:0 up to bits 31:24.
- R4: Exactly the programmed number of bytes is transferred, after which `out_valid` falls.
- R5: A byte count larger than 32 behaves as 32.
- R6: With the enable bit clear, a frame-start strobe has no effect.
- R7: A frame-start strobe that arrives while a sequence is being emitted is ignored. The current sequence continues unchanged and is not restarted.
- R8: A slot write made during emission changes only the sequences of later frames.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R10: With enable held set, each later frame start sends the same list again.
- R11: A byte count of zero emits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register write address |
| reg_wdata | input | 32 | Register write data |
| frame_start | input | 1 | One-cycle frame start pulse |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | 8 | Output byte |

## Verification
The assertions assume that `out_ready` is a plain level the downstream side may change in any cycle. They also assume that `frame_start` may arrive at any time, including in the middle of a sequence. Stall and strobe-during-emission assertions therefore rely on nothing more than the clock. The bench applies a fixed irregular ready pattern for back-pressure, and it places extra strobes and slot writes deliberately inside active sequences. It drives every input one half-cycle away from the sampling edge.

// File: rtl/fci_pkg.sv
package fci_pkg;
  localparam int unsigned REG_ADDR_W = 8;
  localparam int unsigned CNT_FIELD_W = 16;
  localparam int unsigned EN_BIT = 31;
  localparam logic [REG_ADDR_W-1:0] CTRL_ADDR = 8'h1a;
  localparam logic [REG_ADDR_W-1:0] SLOT_BASE = 8'h1b;

  typedef struct packed {
    logic                   en;
    logic [CNT_FIELD_W-1:0] count;
  } ctrl_t;
endpackage

// File: rtl/fci_regs.sv
module fci_regs
  import fci_pkg::*;
#(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned NUM_SLOTS = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we,
  input  logic [REG_ADDR_W-1:0]             addr,
  input  logic [WORD_W-1:0]                 wdata,
  output logic [NUM_SLOTS-1:0][WORD_W-1:0]  slots_q,
  output ctrl_t                             ctrl_q
);
  ctrl_t ctrl_d;
  logic  ctrl_wen;

  assign ctrl_wen = we && (addr == CTRL_ADDR);

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wen) begin
      ctrl_d.en    = wdata[EN_BIT];
      ctrl_d.count = wdata[CNT_FIELD_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    logic              slot_wen;
    logic [WORD_W-1:0] slot_d;
    assign slot_wen = we && (addr == SLOT_BASE + REG_ADDR_W'(k));
    always_comb slot_d = slot_wen ? wdata : slots_q[k];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slots_q[k] <= '0;
      else        slots_q[k] <= slot_d;
    end
  end

  assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wen |=> (ctrl_q.en == $past(wdata[EN_BIT])));
endmodule

// File: rtl/fci_snapshot.sv
module fci_snapshot
  import fci_pkg::*;
#(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned NUM_SLOTS = 8,
  localparam int unsigned MAX_BYTES = NUM_SLOTS * (WORD_W / 8),
  localparam int unsigned CNT_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              load,
  input  logic [NUM_SLOTS-1:0][WORD_W-1:0]  slots_in,
  input  logic [CNT_FIELD_W-1:0]            count_in,
  output logic [CNT_W-1:0]                  limit_next,
  output logic [NUM_SLOTS-1:0][WORD_W-1:0]  snap_q,
  output logic [CNT_W-1:0]                  limit_q
);
  logic [NUM_SLOTS-1:0][WORD_W-1:0] snap_d;
  logic [CNT_W-1:0]                 limit_d;

  always_comb begin
    if (count_in > CNT_FIELD_W'(MAX_BYTES)) limit_next = CNT_W'(MAX_BYTES);
    else                                    limit_next = count_in[CNT_W-1:0];
  end

  always_comb begin
    snap_d  = snap_q;
    limit_d = limit_q;
    if (load) begin
      snap_d  = slots_in;
      limit_d = limit_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q  <= '0;
      limit_q <= '0;
    end else begin
      snap_q  <= snap_d;
      limit_q <= limit_d;
    end
  end

  assert_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    limit_q <= CNT_W'(MAX_BYTES));
  assert_snap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(snap_q));
endmodule

// File: rtl/fci_seq.sv
module fci_seq #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned NUM_SLOTS = 8,
  localparam int unsigned BYTES_PER_WORD = WORD_W / 8,
  localparam int unsigned MAX_BYTES = NUM_SLOTS * BYTES_PER_WORD,
  localparam int unsigned CNT_W     = $clog2(MAX_BYTES + 1),
  localparam int unsigned LANE_W    = $clog2(BYTES_PER_WORD),
  localparam int unsigned SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              frame_start,
  input  logic                              enable,
  input  logic [CNT_W-1:0]                  limit_next,
  input  logic [NUM_SLOTS-1:0][WORD_W-1:0]  snap,
  input  logic [CNT_W-1:0]                  limit_q,
  output logic                              load,
  input  logic                              out_ready,
  output logic                              out_valid,
  output logic [7:0]                        out_data
);
  logic             busy_q, busy_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic             fire;
  logic [SLOT_W-1:0] slot_sel;
  logic [LANE_W-1:0] lane_sel;
  logic [WORD_W-1:0] cur_word;

  assign load      = frame_start && enable && !busy_q && (limit_next != '0);
  assign fire      = busy_q && out_ready;
  assign out_valid = busy_q;

  assign lane_sel = idx_q[LANE_W-1:0];
  assign slot_sel = idx_q[LANE_W +: SLOT_W];
  assign cur_word = snap[slot_sel];
  assign out_data = 8'(cur_word >> {lane_sel, 3'b000});

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    if (load) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (fire) begin
      idx_d = idx_q + 1'b1;
      if (idx_q + 1'b1 == limit_q) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
    end
  end

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  assert_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (idx_q < limit_q));
  assert_start_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (idx_q == '0));
  assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && frame_start && !out_ready) |=> (busy_q && $stable(idx_q)));
endmodule

// File: rtl/frame_cmd_injector.sv
module frame_cmd_injector
  import fci_pkg::*;
#(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned NUM_SLOTS = 8,
  localparam int unsigned MAX_BYTES = NUM_SLOTS * (WORD_W / 8),
  localparam int unsigned CNT_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0]     reg_wdata,
  input  logic                  frame_start,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [7:0]            out_data
);
  logic [NUM_SLOTS-1:0][WORD_W-1:0] slots_q, snap_q;
  ctrl_t                            ctrl_q;
  logic [CNT_W-1:0]                 limit_next, limit_q;
  logic                             load;

  fci_regs #(.WORD_W(WORD_W), .NUM_SLOTS(NUM_SLOTS)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .slots_q(slots_q), .ctrl_q(ctrl_q)
  );

  fci_snapshot #(.WORD_W(WORD_W), .NUM_SLOTS(NUM_SLOTS)) u_snap (
    .clk(clk), .rst_n(rst_n), .load(load), .slots_in(slots_q),
    .count_in(ctrl_q.count), .limit_next(limit_next),
    .snap_q(snap_q), .limit_q(limit_q)
  );

  fci_seq #(.WORD_W(WORD_W), .NUM_SLOTS(NUM_SLOTS)) u_seq (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .enable(ctrl_q.en), .limit_next(limit_next), .snap(snap_q),
    .limit_q(limit_q), .load(load), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data)
  );

  assert_idle_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !ctrl_q.en) |=> !out_valid);
endmodule

// File: tb/tb_frame_cmd_injector.sv
module tb_frame_cmd_injector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        frame_start = 1'b0;
  logic        out_ready = 1'b1;
  logic        out_valid;
  logic [7:0]  out_data;

  int total = 0;
  int bad = 0;
  bit bp_mode = 1'b0;
  int cyc = 0;

  logic [31:0] model_slot [8];
  logic [31:0] exp_word [8];
  logic [7:0]  cap [64];
  int          cap_n = 0;

  logic        prev_stall = 1'b0;
  logic [7:0]  prev_data = '0;

  always #10 clk = ~clk;

  frame_cmd_injector dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .frame_start(frame_start),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  always @(negedge clk) begin
    cyc++;
    out_ready = bp_mode ? ((cyc % 3) == 0 || (cyc % 7) == 1) : 1'b1;
    #2;
    if (prev_stall) begin
      total++;
      if (!(out_valid && out_data == prev_data)) begin
        bad++;
        $display("FAIL R9 stall hold: valid=%0b data=%02h expected valid=1 data=%02h",
                 out_valid, out_data, prev_data);
      end
    end
    if (out_valid && out_ready && cap_n < 64) begin
      cap[cap_n] = out_data;
      cap_n++;
    end
    prev_stall = out_valid && !out_ready;
    prev_data  = out_data;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (a >= 8'h1b && a <= 8'h22) model_slot[a - 8'h1b] = d;
  endtask

  task automatic set_ctrl(input bit en, input logic [15:0] cnt);
    wr(8'h1a, {en, 15'd0, cnt});
  endtask

  task automatic pulse();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic arm();
    for (int i = 0; i < 8; i++) exp_word[i] = model_slot[i];
    @(negedge clk);
    cap_n = 0;
  endtask

  task automatic check_frame(input string req, input int n);
    check({req, " byte count"}, cap_n, n);
    for (int k = 0; k < n && k < cap_n; k++)
      check({req, " byte value"}, cap[k], 8'(exp_word[k / 4] >> (8 * (k % 4))));
  endtask

  task automatic t_reset();
    check("R1 valid after reset", out_valid, 0);
    arm(); pulse(); repeat (10) @(negedge clk);
    check_frame("R1 no emission after reset", 0);
  endtask

  task automatic t_basic();
    for (int i = 0; i < 8; i++) wr(8'h1b + 8'(i), 32'h1500_0000 ^ (32'h0103_0507 * (i + 3)));
    set_ctrl(1'b1, 16'd8);
    arm(); pulse();
    @(negedge clk); #3;
    check("R3 valid one cycle after strobe", out_valid, 1);
    repeat (20) @(negedge clk);
    check_frame("R2 R3 R4 basic", 8);
    check("R4 valid low after last", out_valid, 0);
  endtask

  task automatic t_repeat();
    arm(); pulse(); repeat (20) @(negedge clk);
    check_frame("R10 second frame", 8);
  endtask

  task automatic t_clamp();
    set_ctrl(1'b1, 16'd40);
    arm(); pulse(); repeat (50) @(negedge clk);
    check_frame("R5 clamp to 32", 32);
  endtask

  task automatic t_disabled();
    set_ctrl(1'b0, 16'd8);
    arm(); pulse(); repeat (20) @(negedge clk);
    check_frame("R6 disabled", 0);
  endtask

  task automatic t_zero();
    set_ctrl(1'b1, 16'd0);
    arm(); pulse(); repeat (20) @(negedge clk);
    check_frame("R11 zero count", 0);
  endtask

  task automatic t_restart();
    set_ctrl(1'b1, 16'd12);
    arm(); pulse();
    repeat (3) @(negedge clk);
    pulse();
    repeat (20) @(negedge clk);
    check_frame("R7 strobe during emission", 12);
  endtask

  task automatic t_midwrite();
    set_ctrl(1'b1, 16'd16);
    arm(); pulse();
    wr(8'h1e, 32'hdead_beef);
    repeat (20) @(negedge clk);
    check_frame("R8 old data in current frame", 16);
    arm(); pulse(); repeat (25) @(negedge clk);
    check_frame("R8 new data next frame", 16);
  endtask

  task automatic t_backpressure();
    set_ctrl(1'b1, 16'd32);
    bp_mode = 1'b1;
    arm(); pulse(); repeat (150) @(negedge clk);
    bp_mode = 1'b0;
    check_frame("R9 back-pressure", 32);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) model_slot[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic();
    t_repeat();
    t_clamp();
    t_disabled();
    t_zero();
    t_restart();
    t_midwrite();
    t_backpressure();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule